// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block arbitrates eight interrupt request lines in the manner of a classic PC-style interrupt controller, and it keeps track of which lines are currently being serviced. Capture of requests and decoding of host registers sit outside the block. The block receives several inputs:

- the pending vector and the mask vector;
- a per-line trigger-type vector;
- the mode flags;
- a vector base.

It holds two pieces of state: the in-service vector and a rotating priority offset.

Every cycle the block finds the best unmasked pending line. Priority is counted from the offset. It compares that line against the best in-service level and drives a registered interrupt output. An acknowledge strobe returns the vector of the winning line. On that strobe the block marks the line in service and pulses a clear for edge-triggered requests. A command strobe carries a 3-bit code and a line number, and performs end-of-interrupt and priority-rotation operations.

Top module: `prio_irq_resolver`

## Requirements
- R1: After synchronous reset, the in-service vector is 0, the offset is 0, and the interrupt output, acknowledge-valid and pending-clear outputs are all 0.
- R2: Scan position p (0 = highest) tests line (p + offset) mod 8. The winner is the unmasked pending line at the lowest scan position.
- R3: The interrupt output is registered. At a clock edge it becomes 1 exactly when the winner's scan position is strictly lower than the scan position of the best in-service line, where an empty set counts as position 8.
- R4: With the special-mask flag set, masked lines are removed from the in-service vector before the current level is found.
- R5: With the fully-nested flag and the master flag both set, in-service bit 2 (the cascade line) is ignored when the current level is found.
- R6: On acknowledge with auto-EOI off, the next cycle shows ack_valid = 1, ack_vector = {vec_base[7:3], line}, and the winner's in-service bit set.
- R7: On acknowledge with auto-EOI on, no in-service bit is set. If rotate-on-auto-EOI is also on, the offset becomes (line + 1) mod 8.
- R8: On acknowledge, pend_clr pulses the winner's bit for one cycle only if that line is edge-triggered (trig_level bit = 0). Level-triggered lines get no clear.
- R9: An acknowledge with no unmasked pending line reports line 7, changes no state, and clears nothing.
- R10: Command code 3'b001 clears the in-service bit at the lowest scan position. Code 3'b101 does the same and also sets the offset to (that line + 1) mod 8.
- R11: Code 3'b011 clears in-service bit cmd_line. Code 3'b111 clears it and also sets the offset to (cmd_line + 1) mod 8.
- R12: Code 3'b110 sets the offset to (cmd_line + 1) mod 8 and leaves the in-service vector unchanged.
- R13: Codes 3'b000, 3'b010 and 3'b100 change neither the in-service vector nor the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend | input | 8 | Pending request vector |
| mask | input | 8 | Mask vector |
| trig_level | input | 8 | 1 = level-triggered line |
| vec_base | input | 8 | Vector base; upper 5 bits used |
| spec_mask_en | input | 1 | Special-mask mode |
| nested_en | input | 1 | Special fully-nested mode |
| is_master | input | 1 | Unit is the cascade master |
| auto_eoi | input | 1 | Auto end-of-interrupt on acknowledge |
| rot_on_aeoi | input | 1 | Rotate on auto end-of-interrupt |
| ack | input | 1 | Acknowledge strobe |
| cmd_valid | input | 1 | Command strobe, never with ack |
| cmd_code | input | 3 | Command code |
| cmd_line | input | 3 | Command line number |
| irq | output | 1 | Registered interrupt request |
| ack_valid | output | 1 | Acknowledge response valid |
| ack_vector | output | 8 | Delivered vector |
| pend_clr | output | 8 | One-cycle clear pulse for a pending bit |
| in_service | output | 8 | In-service vector |
| prio_offset | output | 3 | Rotating priority offset |

## Verification
Some properties are checked on every cycle by assertions:

- the scanner's chosen line is always a requested line;
- the pending-clear pulse is at most one-hot and is never raised for a level-triggered line;
- a normal acknowledge sets its in-service bit;
- a specific end-of-interrupt clears its bit;
- set-priority moves the offset without touching service state.

Other behaviour can only be shown by the bench's directed scenarios:

- rotated scan order;
- the strict comparison against the current level;
- the special-mask and fully-nested exemptions;
- spurious acknowledges;
- the rotating forms of end-of-interrupt.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned NLINES = 8;
  localparam int unsigned LW = $clog2(NLINES);

  typedef enum logic [2:0] {
    CMD_EOI_ANY      = 3'b001,
    CMD_EOI_ANY_ROT  = 3'b101,
    CMD_EOI_LINE     = 3'b011,
    CMD_EOI_LINE_ROT = 3'b111,
    CMD_SET_PRIO     = 3'b110
  } cmd_e;
endpackage

// File: rtl/rot_scan.sv
// Rotating-offset priority scanner: lowest scan position wins.
module rot_scan #(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [LW-1:0] base,
  output logic [LW:0]   rank,
  output logic [LW-1:0] line,
  output logic          hit
);
  logic [LW-1:0] idx;

  always_comb begin
    rank = (LW+1)'(N);
    line = '0;
    idx  = '0;
    for (int p = N - 1; p >= 0; p--) begin
      idx = base + LW'(p);
      if (req[idx]) begin
        rank = (LW+1)'(p);
        line = idx;
      end
    end
    hit = (rank != (LW+1)'(N));
  end

  // R2: a reported line must be a requesting line
  always_comb begin
    if (hit) p_scan_hit_r2: assert (req[line]);
  end
endmodule

// File: rtl/svc_update.sv
// Next-state logic for the in-service vector and the rotation offset.
module svc_update #(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = $clog2(N)
) (
  input  logic [N-1:0]  isr,
  input  logic [LW-1:0] off,
  input  logic          ack,
  input  logic          win_hit,
  input  logic [LW-1:0] win_line,
  input  logic          auto_eoi,
  input  logic          rot_on_aeoi,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_code,
  input  logic [LW-1:0] cmd_line,
  input  logic          top_hit,
  input  logic [LW-1:0] top_line,
  output logic [N-1:0]  isr_nxt,
  output logic [LW-1:0] off_nxt
);
  import prio_irq_pkg::*;

  always_comb begin
    isr_nxt = isr;
    off_nxt = off;
    if (ack && win_hit) begin
      if (auto_eoi) begin
        if (rot_on_aeoi) off_nxt = win_line + LW'(1);
      end else begin
        isr_nxt[win_line] = 1'b1;
      end
    end else if (cmd_valid) begin
      case (cmd_code)
        CMD_EOI_ANY: if (top_hit) isr_nxt[top_line] = 1'b0;
        CMD_EOI_ANY_ROT: if (top_hit) begin
          isr_nxt[top_line] = 1'b0;
          off_nxt = top_line + LW'(1);
        end
        CMD_EOI_LINE: isr_nxt[cmd_line] = 1'b0;
        CMD_EOI_LINE_ROT: begin
          isr_nxt[cmd_line] = 1'b0;
          off_nxt = cmd_line + LW'(1);
        end
        CMD_SET_PRIO: off_nxt = cmd_line + LW'(1);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/prio_irq_resolver.sv
module prio_irq_resolver #(
  parameter int unsigned N        = prio_irq_pkg::NLINES,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned CASC_BIT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     pend,
  input  logic [N-1:0]     mask,
  input  logic [N-1:0]     trig_level,
  input  logic [VEC_W-1:0] vec_base,
  input  logic             spec_mask_en,
  input  logic             nested_en,
  input  logic             is_master,
  input  logic             auto_eoi,
  input  logic             rot_on_aeoi,
  input  logic             ack,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_code,
  input  logic [$clog2(N)-1:0] cmd_line,
  output logic             irq,
  output logic             ack_valid,
  output logic [VEC_W-1:0] ack_vector,
  output logic [N-1:0]     pend_clr,
  output logic [N-1:0]     in_service,
  output logic [$clog2(N)-1:0] prio_offset
);
  localparam int unsigned LW = $clog2(N);
  localparam logic [LW-1:0] SPUR_LINE = LW'(N - 1);

  logic [N-1:0]  isr_q, isr_nxt, cand, lvl_set;
  logic [LW-1:0] off_q, off_nxt;
  logic [LW:0]   cand_rank, lvl_rank, top_rank;
  logic [LW-1:0] cand_line, lvl_line, top_line;
  logic          cand_hit, lvl_hit, top_hit;
  logic [LW-1:0] ack_line;

  assign cand = pend & ~mask;

  always_comb begin
    lvl_set = isr_q;
    if (spec_mask_en) lvl_set = lvl_set & ~mask;
    if (nested_en && is_master) lvl_set[CASC_BIT] = 1'b0;
  end

  rot_scan #(.N(N), .LW(LW)) u_cand (
    .req(cand), .base(off_q), .rank(cand_rank), .line(cand_line), .hit(cand_hit));
  rot_scan #(.N(N), .LW(LW)) u_level (
    .req(lvl_set), .base(off_q), .rank(lvl_rank), .line(lvl_line), .hit(lvl_hit));
  rot_scan #(.N(N), .LW(LW)) u_top (
    .req(isr_q), .base(off_q), .rank(top_rank), .line(top_line), .hit(top_hit));

  svc_update #(.N(N), .LW(LW)) u_upd (
    .isr(isr_q), .off(off_q), .ack(ack), .win_hit(cand_hit), .win_line(cand_line),
    .auto_eoi(auto_eoi), .rot_on_aeoi(rot_on_aeoi), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_line(cmd_line), .top_hit(top_hit), .top_line(top_line),
    .isr_nxt(isr_nxt), .off_nxt(off_nxt));

  assign ack_line = cand_hit ? cand_line : SPUR_LINE;

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q      <= '0;
      off_q      <= '0;
      irq        <= 1'b0;
      ack_valid  <= 1'b0;
      ack_vector <= '0;
      pend_clr   <= '0;
    end else begin
      isr_q      <= isr_nxt;
      off_q      <= off_nxt;
      irq        <= cand_rank < lvl_rank;
      ack_valid  <= ack;
      pend_clr   <= '0;
      if (ack) begin
        ack_vector <= {vec_base[VEC_W-1:LW], ack_line};
        if (cand_hit && !trig_level[cand_line]) pend_clr[cand_line] <= 1'b1;
      end
    end
  end

  assign in_service  = isr_q;
  assign prio_offset = off_q;

  // R8: at most one clear, never for a level-triggered line
  p_clr_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pend_clr));
  p_clr_edge_only_r8: assert property (@(posedge clk) disable iff (rst)
    ack && cand_hit && trig_level[cand_line] |=> pend_clr == '0);
  // R6: a normal acknowledge sets the winner's in-service bit
  p_ack_sets_isr_r6: assert property (@(posedge clk) disable iff (rst)
    ack && cand_hit && !auto_eoi |=> in_service[$past(cand_line)]);
  // R11: a specific end-of-interrupt clears the named bit
  p_eoi_line_r11: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !ack && cmd_code[1:0] == 2'b11 |=> !in_service[$past(cmd_line)]);
  // R12: set-priority moves the offset, service state stays
  p_set_prio_r12: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !ack && cmd_code == 3'b110 |=>
      prio_offset == $past(cmd_line) + LW'(1) && $stable(in_service));
  // R9: a spurious acknowledge leaves service state unchanged
  p_spurious_r9: assert property (@(posedge clk) disable iff (rst)
    ack && !cand_hit |=> $stable(in_service) && $stable(prio_offset));
endmodule

// File: tb/tb_prio_irq_resolver.sv
module tb_prio_irq_resolver;
  logic clk = 0, rst = 1;
  logic [7:0] pend = 0, mask = 0, trig_level = 0, vec_base = 8'h40;
  logic spec_mask_en = 0, nested_en = 0, is_master = 0, auto_eoi = 0, rot_on_aeoi = 0;
  logic ack = 0, cmd_valid = 0;
  logic [2:0] cmd_code = 0, cmd_line = 0;
  logic irq, ack_valid;
  logic [7:0] ack_vector, pend_clr, in_service;
  logic [2:0] prio_offset;
  int errs = 0, checks = 0;

  always #5 clk = ~clk;

  prio_irq_resolver dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic do_ack();
    @(negedge clk) ack = 1;
    @(posedge clk) #1;
    @(negedge clk) ack = 0;
  endtask

  task automatic do_cmd(input logic [2:0] c, input logic [2:0] l);
    @(negedge clk) begin cmd_valid = 1; cmd_code = c; cmd_line = l; end
    @(negedge clk) cmd_valid = 0;
  endtask

  task automatic t_reset();
    chk("R1 isr", in_service, 0); chk("R1 off", prio_offset, 0);
    chk("R1 irq", irq, 0); chk("R1 ackv", ack_valid, 0); chk("R1 clr", pend_clr, 0);
  endtask

  task automatic t_basic();
    @(negedge clk) pend = 8'h28; settle();
    chk("R3 irq on winner", irq, 1);
    @(negedge clk) ack = 1;
    @(posedge clk) #1;
    chk("R6 ackv", ack_valid, 1); chk("R6 vec", ack_vector, 8'h43);
    chk("R8 edge clr", pend_clr, 8'h08); chk("R6 isr", in_service, 8'h08);
    @(negedge clk) begin ack = 0; pend = 8'h20; end
    settle(); chk("R3 lower prio blocked", irq, 0);
    @(negedge clk) pend = 8'h21; settle(); chk("R3 higher prio passes", irq, 1);
    do_cmd(3'b001, 0); #1; chk("R10 eoi any", in_service, 0);
  endtask

  task automatic t_rotate();
    do_cmd(3'b110, 3'd4); #1;
    chk("R12 offset", prio_offset, 5); chk("R12 isr", in_service, 0);
    @(negedge clk) pend = 8'h21;
    @(negedge clk) ack = 1; @(posedge clk) #1;
    chk("R2 rotated winner", ack_vector, 8'h45); chk("R6 isr5", in_service, 8'h20);
    @(negedge clk) ack = 0;
    do_cmd(3'b101, 0); #1;
    chk("R10 rot eoi isr", in_service, 0); chk("R10 rot eoi off", prio_offset, 6);
    @(negedge clk) pend = 8'h81;
    @(negedge clk) ack = 1; @(posedge clk) #1;
    chk("R2 wrap winner", ack_vector, 8'h47);
    @(negedge clk) ack = 0;
    do_cmd(3'b011, 3'd7); #1; chk("R11 eoi line", in_service, 0);
    do_cmd(3'b111, 3'd2); #1;
    chk("R11 rot line off", prio_offset, 3); chk("R11 rot line isr", in_service, 0);
  endtask

  task automatic t_level_spur();
    @(negedge clk) begin trig_level = 8'h02; pend = 8'h02; end
    @(negedge clk) ack = 1; @(posedge clk) #1;
    chk("R8 level no clr", pend_clr, 0); chk("R6 level isr", in_service, 8'h02);
    chk("R2 level vec", ack_vector, 8'h41);
    @(negedge clk) begin ack = 0; pend = 0; end
    @(negedge clk) ack = 1; @(posedge clk) #1;
    chk("R9 spur vec", ack_vector, 8'h47); chk("R9 spur clr", pend_clr, 0);
    chk("R9 spur isr", in_service, 8'h02); chk("R9 spur off", prio_offset, 3);
    @(negedge clk) ack = 0;
  endtask

  task automatic t_special_mask();
    do_cmd(3'b110, 3'd7); #1; chk("R12 offset wrap", prio_offset, 0);
    @(negedge clk) pend = 8'h04; settle(); chk("R3 blocked by isr1", irq, 0);
    @(negedge clk) begin mask = 8'h02; spec_mask_en = 1; end
    settle(); chk("R4 special mask", irq, 1);
    @(negedge clk) spec_mask_en = 0; settle(); chk("R4 mask alone", irq, 0);
    do_cmd(3'b000, 3'd1); do_cmd(3'b010, 3'd1); do_cmd(3'b100, 3'd1); #1;
    chk("R13 isr", in_service, 8'h02); chk("R13 off", prio_offset, 0);
    @(negedge clk) mask = 0;
    do_cmd(3'b011, 3'd1); #1; chk("R11 clear1", in_service, 0);
  endtask

  task automatic t_nested();
    @(negedge clk) begin pend = 8'h04; trig_level = 0; end
    do_ack(); chk("R6 isr2", in_service, 8'h04);
    settle(); chk("R3 equal level", irq, 0);
    @(negedge clk) begin nested_en = 1; is_master = 1; end
    settle(); chk("R5 nested master", irq, 1);
    @(negedge clk) is_master = 0; settle(); chk("R5 not master", irq, 0);
    @(negedge clk) nested_en = 0;
    do_cmd(3'b011, 3'd2); #1;
  endtask

  task automatic t_aeoi();
    @(negedge clk) begin auto_eoi = 1; pend = 8'h08; end
    @(negedge clk) ack = 1; @(posedge clk) #1;
    chk("R7 aeoi isr", in_service, 0); chk("R7 aeoi off", prio_offset, 0);
    chk("R7 vec", ack_vector, 8'h43);
    @(negedge clk) begin ack = 0; rot_on_aeoi = 1; end
    do_ack(); chk("R7 rotate", prio_offset, 4); chk("R7 rot isr", in_service, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        #1 t_reset();
        t_basic(); t_rotate(); t_level_spur(); t_special_mask(); t_nested(); t_aeoi();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errs++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule